// File: doc/BRIEF.md
# Transmit Descriptor Ring Reader

This block drives the transmit side of an Ethernet controller from a ring of descriptors in memory. Each descriptor takes two 32-bit words. The word at offset 0 holds the address of a frame buffer. The word at offset 4 holds the buffer length, per-frame flags and an ownership bit. Software fills descriptors and clears their ownership bit. It then pulses `start`. The engine walks the ring from the base address, reads each buffer through a word-wide memory read port and presents its bytes on a byte stream with first-byte and last-byte markers.

After it consumes a buffer, the engine writes the control word back with the ownership bit set, so the buffer returns to software. If a frame fails, the write-back also carries one error bit and the engine stops. A halt request lets the frame in flight finish before the engine goes idle. `busy` stays high for as long as the engine is walking the ring. The engine keeps its ring position between runs, so each later `start` resumes where the previous run stopped.

Top module: `txdesc_ring_reader`

## Requirements
- R1: After reset, `busy`, `mem_rd_req`, `mem_wr_req`, `tx_valid` and `frame_abort` are all low.
- R2: The first `start` after reset begins at `ring_base`. For each descriptor the engine reads the control word at offset 4 and then the buffer address at offset 0. It sends the number of bytes given by control bits 10:0 in ascending address order. The byte at address A sits in bits 8*(A mod 4)+7 down to 8*(A mod 4) of the word at A rounded down to a multiple of 4. A read request holds its address until it is acknowledged.
- R3: `tx_sof` marks the first byte of a frame. `tx_eof` marks the last byte of a buffer whose control bit 15 is set. Buffers without bit 15 continue the same frame. `tx_nocrc` accompanies every byte whose descriptor has control bit 16 set.
- R4: Once a buffer has been sent, the control word is written back to offset 4. Bit 31 is set, bits 29:27 are cleared and every other bit is kept.
- R5: A descriptor with control bit 30 set is followed by the descriptor at `ring_base`. Any other descriptor is followed by the one 8 bytes above it.
- R6: If the engine reads a control word with bit 31 set between frames, it goes idle without writing anything. The next `start` re-reads that same descriptor.
- R7: If the engine finds bit 31 set partway through a frame, it writes that descriptor's control word back with bits 31 and 27 set. It then pulses `frame_abort` for one cycle after going idle, and the next `start` resumes at that descriptor.
- R8: A buffer read acknowledged with `mem_rd_err` stops the stream before the byte that read would have supplied. The descriptor is written back with bits 31 and 28 set, `frame_abort` pulses, the engine goes idle and its position moves past that descriptor.
- R9: `retry_fail` seen while a byte is offered aborts the frame. The descriptor is written back with bits 31 and 29 set, `frame_abort` pulses and the engine goes idle.
- R10: A `halt` pulse during a frame lets that frame finish, with `busy` high until its last write-back. No further descriptor is read, and the next `start` continues with the following descriptor.
- R11: While `tx_valid` is high and `tx_ready` is low, the offered byte and its markers hold steady. No byte is lost or repeated.
- R12: `start` while `busy` is high has no effect. At most one of `mem_rd_req`, `mem_wr_req` and `tx_valid` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_base | input | AW | Byte address of the first descriptor, 8-byte aligned |
| start | input | 1 | Pulse that launches ring processing |
| halt | input | 1 | Pulse that requests a stop at the next frame boundary |
| busy | output | 1 | Engine is walking the ring |
| mem_rd_req | output | 1 | Word read request, held until acknowledged |
| mem_rd_addr | output | AW | Byte address of the word to read |
| mem_rd_ack | input | 1 | Read data valid this cycle |
| mem_rd_data | input | 32 | Read data |
| mem_rd_err | input | 1 | The acknowledged read failed |
| mem_wr_req | output | 1 | Write-back request, held until acknowledged |
| mem_wr_addr | output | AW | Byte address of the control word written back |
| mem_wr_data | output | 32 | Written-back control word |
| mem_wr_ack | input | 1 | Write accepted this cycle |
| tx_valid | output | 1 | A byte is offered |
| tx_data | output | 8 | Offered byte |
| tx_sof | output | 1 | Offered byte opens a frame |
| tx_eof | output | 1 | Offered byte closes a frame |
| tx_nocrc | output | 1 | Frame is sent without an appended CRC |
| tx_ready | input | 1 | Consumer takes the offered byte this cycle |
| retry_fail | input | 1 | Transmit side gave up on the frame after retries |
| frame_abort | output | 1 | One-cycle pulse after a frame is aborted |

## Verification
The bench builds the block with AW = 12. This puts the ring, the buffers and the write-back targets inside a 4 KiB word-array model, so every descriptor word can be inspected after each run. An 8-slot ring at a non-zero base lets a run pass through the wrap bit and back to the base within a few dozen cycles. Buffers at all four byte offsets and of lengths from 1 to 40 exercise partial first and last words. A failing-read address planted in the model triggers the underrun path.

// File: rtl/txdesc_ring_reader.sv
`timescale 1ns/1ps
module txdesc_ring_reader #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ring_base,
  input  logic          start,
  input  logic          halt,
  output logic          busy,
  output logic          mem_rd_req,
  output logic [AW-1:0] mem_rd_addr,
  input  logic          mem_rd_ack,
  input  logic [31:0]   mem_rd_data,
  input  logic          mem_rd_err,
  output logic          mem_wr_req,
  output logic [AW-1:0] mem_wr_addr,
  output logic [31:0]   mem_wr_data,
  input  logic          mem_wr_ack,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  output logic          tx_sof,
  output logic          tx_eof,
  output logic          tx_nocrc,
  input  logic          tx_ready,
  input  logic          retry_fail,
  output logic          frame_abort
);
  localparam int LEN_W = 11;
  localparam int B_LAST = 15;
  localparam int B_NOCRC = 16;
  localparam int B_WRAP = 30;
  localparam logic [31:0] USED_BIT = 32'h8000_0000;
  localparam logic [31:0] EXH_BIT  = 32'h0800_0000;
  localparam logic [31:0] UND_BIT  = 32'h1000_0000;
  localparam logic [31:0] RTY_BIT  = 32'h2000_0000;
  localparam logic [31:0] ERR_MASK = EXH_BIT | UND_BIT | RTY_BIT;
  localparam logic [AW-1:0] STEP = AW'(8);
  localparam logic [AW-1:0] CTL_OFS = AW'(4);

  typedef enum logic [2:0] {S_IDLE, S_RCTL, S_RADR, S_FETCH, S_SEND, S_WB} st_t;

  st_t st;
  logic [AW-1:0] ptr, baddr;
  logic [31:0] ctrl, word, wb;
  logic [LEN_W-1:0] cnt;
  logic ptr_ok, in_frame, sof_pend, halt_pend, stop_after, keep_ptr, abort_q;

  function automatic logic [31:0] wb_word(input logic [31:0] c, input logic [31:0] e);
    return (c & ~ERR_MASK) | USED_BIT | e;
  endfunction

  wire [LEN_W-1:0] len = ctrl[LEN_W-1:0];
  wire last_byte = (cnt == len - 1'b1);
  wire [AW-1:0] next_ptr = ctrl[B_WRAP] ? ring_base : ptr + STEP;

  assign busy        = (st != S_IDLE);
  assign mem_rd_req  = (st == S_RCTL) || (st == S_RADR) || (st == S_FETCH);
  assign mem_rd_addr = (st == S_RCTL) ? ptr + CTL_OFS :
                       (st == S_RADR) ? ptr : {baddr[AW-1:2], 2'b00};
  assign mem_wr_req  = (st == S_WB);
  assign mem_wr_addr = ptr + CTL_OFS;
  assign mem_wr_data = wb;
  assign tx_valid    = (st == S_SEND);
  assign tx_data     = word[{baddr[1:0], 3'b000} +: 8];
  assign tx_sof      = tx_valid && sof_pend;
  assign tx_eof      = tx_valid && ctrl[B_LAST] && last_byte;
  assign tx_nocrc    = tx_valid && ctrl[B_NOCRC];
  assign frame_abort = abort_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      ptr <= '0;
      baddr <= '0;
      ctrl <= '0;
      word <= '0;
      wb <= '0;
      cnt <= '0;
      ptr_ok <= 1'b0;
      in_frame <= 1'b0;
      sof_pend <= 1'b0;
      halt_pend <= 1'b0;
      stop_after <= 1'b0;
      keep_ptr <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      abort_q <= 1'b0;
      if (halt && st != S_IDLE) halt_pend <= 1'b1;
      case (st)
        S_IDLE: begin
          halt_pend <= 1'b0;
          if (start) begin
            if (!ptr_ok) ptr <= ring_base;
            ptr_ok <= 1'b1;
            in_frame <= 1'b0;
            st <= S_RCTL;
          end
        end
        S_RCTL: if (mem_rd_ack) begin
          ctrl <= mem_rd_data;
          if (mem_rd_data[31]) begin
            if (in_frame) begin
              wb <= wb_word(mem_rd_data, EXH_BIT);
              stop_after <= 1'b1;
              keep_ptr <= 1'b1;
              st <= S_WB;
            end else begin
              st <= S_IDLE;
            end
          end else if (!in_frame && halt_pend) begin
            st <= S_IDLE;
          end else begin
            st <= S_RADR;
          end
        end
        S_RADR: if (mem_rd_ack) begin
          baddr <= mem_rd_data[AW-1:0];
          cnt <= '0;
          if (!in_frame) sof_pend <= 1'b1;
          in_frame <= 1'b1;
          if (len == '0) begin
            wb <= wb_word(ctrl, '0);
            st <= S_WB;
          end else begin
            st <= S_FETCH;
          end
        end
        S_FETCH: if (mem_rd_ack) begin
          if (mem_rd_err) begin
            wb <= wb_word(ctrl, UND_BIT);
            stop_after <= 1'b1;
            st <= S_WB;
          end else begin
            word <= mem_rd_data;
            st <= S_SEND;
          end
        end
        S_SEND: begin
          if (retry_fail) begin
            wb <= wb_word(ctrl, RTY_BIT);
            stop_after <= 1'b1;
            st <= S_WB;
          end else if (tx_ready) begin
            sof_pend <= 1'b0;
            baddr <= baddr + 1'b1;
            cnt <= cnt + 1'b1;
            if (last_byte) begin
              wb <= wb_word(ctrl, '0);
              st <= S_WB;
            end else if (baddr[1:0] == 2'b11) begin
              st <= S_FETCH;
            end
          end
        end
        S_WB: if (mem_wr_ack) begin
          if (!keep_ptr) ptr <= next_ptr;
          keep_ptr <= 1'b0;
          stop_after <= 1'b0;
          if (stop_after) begin
            abort_q <= 1'b1;
            in_frame <= 1'b0;
            sof_pend <= 1'b0;
            st <= S_IDLE;
          end else if (ctrl[B_LAST]) begin
            in_frame <= 1'b0;
            st <= halt_pend ? S_IDLE : S_RCTL;
          end else begin
            st <= S_RCTL;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_rd_req && !mem_wr_req && !tx_valid);

  assert_rd_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req && !mem_rd_ack |=> mem_rd_req && $stable(mem_rd_addr));

  assert_wb_owned_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_req |-> mem_wr_data[31]);

  assert_abort_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_abort |-> !busy);

  assert_byte_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready && !retry_fail |=>
      tx_valid && $stable(tx_data) && $stable(tx_sof) && $stable(tx_eof));

  assert_one_action_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_rd_req, mem_wr_req, tx_valid}));
endmodule

// File: tb/txdesc_ring_reader_test.sv
`timescale 1ns/1ps
module txdesc_ring_reader_test;
  localparam int AW = 12;
  localparam logic [AW-1:0] BASE = 12'h040;
  localparam logic [31:0] USED = 32'h8000_0000;
  localparam logic [31:0] LAST = 32'h0000_8000;
  localparam logic [31:0] WRAP = 32'h4000_0000;
  localparam logic [31:0] VEC [0:5] = '{
    32'h0000_0001, 32'h0000_3002, 32'h1000_1005,
    32'h0001_2008, 32'h0001_300D, 32'h0000_0028 };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, halt = 1'b0;
  logic tx_ready = 1'b1, retry_fail = 1'b0;
  logic busy, mem_rd_req, mem_wr_req, tx_valid, tx_sof, tx_eof, tx_nocrc, frame_abort;
  logic mem_rd_ack = 1'b0, mem_rd_err = 1'b0, mem_wr_ack = 1'b0;
  logic [AW-1:0] mem_rd_addr, mem_wr_addr;
  logic [31:0] mem_rd_data = '0, mem_wr_data;
  logic [7:0] tx_data;

  logic [31:0] mem [0:1023];
  logic [AW-1:0] err_addr = 12'hFFF;
  logic [7:0] cap_d [0:511];
  logic cap_s [0:511], cap_e [0:511], cap_n [0:511];
  int ncap = 0, nwr = 0, nabort = 0, n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  txdesc_ring_reader #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .ring_base(BASE), .start(start), .halt(halt), .busy(busy),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_ack(mem_rd_ack),
    .mem_rd_data(mem_rd_data), .mem_rd_err(mem_rd_err),
    .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .mem_wr_ack(mem_wr_ack), .tx_valid(tx_valid), .tx_data(tx_data), .tx_sof(tx_sof),
    .tx_eof(tx_eof), .tx_nocrc(tx_nocrc), .tx_ready(tx_ready), .retry_fail(retry_fail),
    .frame_abort(frame_abort));

  function automatic logic [7:0] pat(input int a);
    return 8'(a * 13 + 7);
  endfunction

  always @(posedge clk) begin
    mem_rd_ack <= 1'b0;
    mem_wr_ack <= 1'b0;
    if (mem_rd_req && !mem_rd_ack) begin
      mem_rd_ack <= 1'b1;
      mem_rd_data <= mem[mem_rd_addr[AW-1:2]];
      mem_rd_err <= (mem_rd_addr == err_addr);
    end
    if (mem_wr_req && !mem_wr_ack) begin
      mem_wr_ack <= 1'b1;
      mem[mem_wr_addr[AW-1:2]] = mem_wr_data;
      nwr <= nwr + 1;
    end
    if (tx_valid && tx_ready) begin
      cap_d[ncap] <= tx_data;
      cap_s[ncap] <= tx_sof;
      cap_e[ncap] <= tx_eof;
      cap_n[ncap] <= tx_nocrc;
      ncap <= ncap + 1;
    end
    if (frame_abort) nabort <= nabort + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic put_desc(input int slot, input int addr, input logic [31:0] ctl);
    mem[(int'(BASE) + 8 * slot) / 4] = 32'(addr);
    mem[(int'(BASE) + 8 * slot) / 4 + 1] = ctl;
  endtask

  function automatic logic [31:0] ctl_of(input int slot);
    return mem[(int'(BASE) + 8 * slot) / 4 + 1];
  endfunction

  function automatic int bad_bytes(input int from, input int addr, input int len);
    int bad = 0;
    for (int i = 0; i < len; i++) if (cap_d[from + i] !== pat(addr + i)) bad++;
    return bad;
  endfunction

  task automatic wait_idle();
    int to = 0;
    while (busy && to < 5000) begin @(negedge clk); to++; end
    repeat (3) @(negedge clk);
  endtask

  task automatic run();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    wait_idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R12 watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int b0, w0, a0, sofs, eofs, bad;
    logic [7:0] d0;
    for (int i = 0; i < 1024; i++)
      mem[i] = {pat(4*i+3), pat(4*i+2), pat(4*i+1), pat(4*i)};
    for (int s = 0; s < 8; s++) put_desc(s, 0, USED);
    repeat (4) @(negedge clk);
    chk(!busy && !mem_rd_req && !mem_wr_req && !tx_valid && !frame_abort, "R1",
        "outputs in reset", {busy, mem_rd_req, mem_wr_req, tx_valid, frame_abort}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !mem_rd_req && !mem_wr_req && !tx_valid, "R1", "idle after reset",
        {busy, mem_rd_req, mem_wr_req, tx_valid}, 0);

    for (int k = 0; k < 6; k++) begin
      int len, addr;
      logic [31:0] ctl;
      len = int'(VEC[k][10:0]);
      addr = 12'h400 + k * 12'h040 + int'(VEC[k][13:12]);
      ctl = (VEC[k] & ~32'h0000_3000) | LAST;
      put_desc(k, addr, ctl);
      put_desc(k + 1, 0, USED);
      b0 = ncap; w0 = nwr;
      run();
      chk(ncap - b0 == len, "R2", "byte count", ncap - b0, len);
      bad = bad_bytes(b0, addr, len);
      chk(bad == 0, "R2", "byte mismatches", bad, 0);
      sofs = 0; eofs = 0; bad = 0;
      for (int i = b0; i < ncap; i++) begin
        sofs += int'(cap_s[i]); eofs += int'(cap_e[i]);
        if (cap_n[i] !== VEC[k][16]) bad++;
      end
      chk(cap_s[b0] && cap_e[ncap-1] && sofs == 1 && eofs == 1, "R3", "markers",
          {sofs[15:0], eofs[15:0]}, 32'h0001_0001);
      chk(bad == 0, "R3", "nocrc flag", bad, 0);
      chk(ctl_of(k) == ((ctl & ~32'h3800_0000) | USED), "R4", "write-back",
          ctl_of(k), (ctl & ~32'h3800_0000) | USED);
      chk(nwr - w0 == 1 && ctl_of(k + 1) == USED, "R6", "owned slot untouched",
          nwr - w0, 1);
    end

    b0 = ncap; w0 = nwr;
    run();
    chk(ncap == b0 && nwr == w0 && !busy, "R6", "stop on owned slot", ncap - b0, 0);

    put_desc(6, 12'h700, 32'd3);
    put_desc(7, 12'h710, 32'd4 | LAST | WRAP);
    put_desc(0, 12'h720, 32'd2 | LAST);
    put_desc(1, 0, USED);
    b0 = ncap; w0 = nwr;
    run();
    bad = bad_bytes(b0, 12'h700, 3) + bad_bytes(b0 + 3, 12'h710, 4) + bad_bytes(b0 + 7, 12'h720, 2);
    chk(ncap - b0 == 9 && bad == 0, "R5", "wrap to base bytes", ncap - b0, 9);
    sofs = 0; eofs = 0;
    for (int i = b0; i < ncap; i++) begin sofs += int'(cap_s[i]); eofs += int'(cap_e[i]); end
    chk(cap_s[b0] && cap_e[b0+6] && cap_s[b0+7] && cap_e[b0+8] && sofs == 2 && eofs == 2,
        "R3", "multi-buffer markers", {sofs[15:0], eofs[15:0]}, 32'h0002_0002);
    chk(ctl_of(7) == (32'd4 | LAST | WRAP | USED) && nwr - w0 == 3, "R5", "wrap write-back",
        ctl_of(7), 32'd4 | LAST | WRAP | USED);

    put_desc(1, 12'h740, 32'd6 | LAST);
    put_desc(2, 0, USED);
    b0 = ncap; w0 = nwr;
    tx_ready = 1'b0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    while (!tx_valid) @(negedge clk);
    d0 = tx_data;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    @(negedge clk);
    chk(tx_valid && tx_sof && tx_data == d0 && d0 == pat(12'h740), "R11", "held byte",
        {24'h0, tx_data}, {24'h0, pat(12'h740)});
    tx_ready = 1'b1;
    wait_idle();
    bad = bad_bytes(b0, 12'h740, 6);
    chk(ncap - b0 == 6 && bad == 0, "R11", "stream after stall", ncap - b0, 6);
    sofs = 0;
    for (int i = b0; i < ncap; i++) sofs += int'(cap_s[i]);
    chk(sofs == 1 && nwr - w0 == 1, "R12", "start while busy ignored", sofs, 1);

    put_desc(2, 12'h760, 32'd5 | LAST);
    put_desc(3, 12'h780, 32'd4 | LAST);
    put_desc(4, 0, USED);
    b0 = ncap;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    while (!tx_valid) @(negedge clk);
    halt = 1'b1;
    @(negedge clk) halt = 1'b0;
    chk(busy, "R10", "busy during drain", busy, 1);
    wait_idle();
    chk(ncap - b0 == 5 && bad_bytes(b0, 12'h760, 5) == 0, "R10", "frame drained", ncap - b0, 5);
    chk(ctl_of(3) == (32'd4 | LAST), "R10", "next slot untouched", ctl_of(3), 32'd4 | LAST);
    b0 = ncap;
    run();
    chk(ncap - b0 == 4 && bad_bytes(b0, 12'h780, 4) == 0, "R10", "resume after halt", ncap - b0, 4);

    put_desc(4, 12'h7A0, 32'd3);
    put_desc(5, 0, USED);
    b0 = ncap; a0 = nabort;
    run();
    chk(ncap - b0 == 3 && !cap_e[ncap-1], "R7", "partial frame", ncap - b0, 3);
    chk(ctl_of(5) == 32'h8800_0000 && ctl_of(4) == (32'd3 | USED), "R7", "exhausted flag",
        ctl_of(5), 32'h8800_0000);
    chk(nabort - a0 == 1 && !busy, "R7", "abort pulse", nabort - a0, 1);

    put_desc(5, 12'h7C0, 32'd6 | LAST);
    put_desc(6, 0, USED);
    err_addr = 12'h7C4;
    b0 = ncap; a0 = nabort;
    run();
    err_addr = 12'hFFF;
    chk(ncap - b0 == 4 && bad_bytes(b0, 12'h7C0, 4) == 0, "R8", "bytes before error", ncap - b0, 4);
    chk(ctl_of(5) == (32'd6 | LAST | USED | 32'h1000_0000) && nabort - a0 == 1, "R8",
        "underrun flag", ctl_of(5), 32'd6 | LAST | USED | 32'h1000_0000);

    put_desc(6, 12'h7E0, 32'd8 | LAST);
    put_desc(7, 0, USED | WRAP);
    b0 = ncap; a0 = nabort;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    while (!tx_valid) @(negedge clk);
    @(negedge clk);
    retry_fail = 1'b1;
    wait_idle();
    retry_fail = 1'b0;
    chk(ncap - b0 >= 1 && ncap - b0 < 8, "R9", "frame cut short", ncap - b0, 1);
    chk(ctl_of(6) == (32'd8 | LAST | USED | 32'h2000_0000) && nabort - a0 == 1, "R9",
        "retry flag", ctl_of(6), 32'd8 | LAST | USED | 32'h2000_0000);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule